// File: doc/BRIEF.md
# Burst Repetition Rate Watchdog

This block sits between a pulse generator and a pulse output stage and decides, cycle by cycle, whether each pulse request may pass. It lets short, fast bursts through but stops a sustained high rate from reaching the output stage. The rate history is held in a leaky-bucket level counter. Each granted pulse raises the level by a charge that depends on the selected pulse width. The level then falls by one every clock. The charge per pulse equals the guaranteed continuous repetition period in clock cycles, so a pulse stream at exactly the continuous rate leaves the level unchanged.

When a grant lifts the level to the configured capacity, the block enters a throttled state. In that state a request passes only if at least one continuous period has elapsed since the last grant, so the output rate falls to the continuous rate. On the same edge a sticky watchdog error flag is set. Throttling ends when the level drains below half of the capacity. The flag stays set until it is cleared explicitly or the block is reset.

With a 125 MHz clock, the default charges are 219 cycles for short pulses (about 571 kHz continuous) and 2404 cycles for long pulses (about 52 kHz continuous). Bursts at 2 MHz and 104 kHz are tolerated until the bucket fills.

Top module: `burst_rate_wdg`

## Requirements
- R1: When not throttled, a request (`pulse_req` high for one cycle) appears as `pulse_grant` high for one cycle on the following clock edge. `pulse_grant` is never high unless `pulse_req` was high in the previous cycle.
- R2: Each grant adds 219 (`width_long`=0) or 2404 (`width_long`=1) to the level. The level falls by one per cycle and stops at zero, so 20 short pulses 62 cycles apart, or 2 long pulses 1202 cycles apart, stay below a capacity of 4096 and are all granted.
- R3: Throttling starts on the grant that brings the level to at least CAPACITY. With CAPACITY 4096 and short pulses every 62 cycles from an empty bucket, 26 pulses are granted and the 27th is dropped. With long pulses every 1202 cycles, 3 are granted and the 4th is dropped.
- R4: While throttled, a request is granted only if at least 219 (short) or 2404 (long) cycles have passed since the cycle of the last granted request.
- R5: Throttling ends only when the level falls below CAPACITY/2. Until then, a second request 62 cycles after a granted one is still dropped.
- R6: `wdg_err` rises on the edge where throttling starts. It stays high after throttling ends.
- R7: `err_clr` high for one cycle clears `wdg_err` on that edge, unless a new trip happens on the same edge; in that case the flag stays set.
- R8: Requests spaced exactly one continuous period apart (219 short, 2404 long) never set `wdg_err` and are all granted.
- R9: Synchronous reset (`rst` high) forces `pulse_grant` and `wdg_err` low, empties the level and ends throttling, so the first requests after reset are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_req | input | 1 | Pulse request from the generator, one cycle per pulse |
| width_long | input | 1 | Width select: 0 short pulse, 1 long pulse |
| err_clr | input | 1 | Clears the watchdog error flag |
| pulse_grant | output | 1 | Registered grant, one cycle per passed pulse |
| wdg_err | output | 1 | Sticky watchdog error flag |

## Verification
A level counter that drains or charges by the wrong amount moves the trip point. It shows up as a first dropped pulse earlier or later than the 27th of a 2 MHz burst, or as a flag raised by a stream at the continuous rate, within a few thousand cycles. A wrong release threshold or a wrong gap counter shows up as the wrong grant pattern on the pulses right after a trip. That happens within a few hundred cycles. A cycle-accurate reference model runs beside the design, so any difference in a single grant cycle or in the flag is reported at the next falling clock edge.

// File: rtl/burst_wdg_pkg.sv
package burst_wdg_pkg;

    // Default charges equal the continuous period in 125 MHz cycles
    localparam int unsigned DEF_INC_SHORT = 219;
    localparam int unsigned DEF_INC_LONG  = 2404;
    localparam int unsigned DEF_CAPACITY  = 4096;

    typedef enum logic {
        PW_SHORT = 1'b0,
        PW_LONG  = 1'b1
    } pw_sel_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdg_bucket.sv
module wdg_bucket
    import burst_wdg_pkg::*;
#(
    parameter int unsigned LVL_W    = 14,
    parameter int unsigned CAPACITY = DEF_CAPACITY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LVL_W-1:0] charge,
    output logic             throttle,
    output logic             trip
);
    localparam logic [LVL_W-1:0] CAP_V  = LVL_W'(CAPACITY);
    localparam logic [LVL_W-1:0] HALF_V = LVL_W'(CAPACITY / 2);

    logic [LVL_W-1:0] level_q, level_d, drained;
    logic             thr_q, thr_d;

    always_comb begin
        drained = (level_q == '0) ? '0 : level_q - 1'b1;
        level_d = drained + (take ? charge : '0);
        trip    = (level_d >= CAP_V);
        if (trip)
            thr_d = 1'b1;
        else if (level_d < HALF_V)
            thr_d = 1'b0;
        else
            thr_d = thr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            thr_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            thr_q   <= thr_d;
        end
    end

    assign throttle = thr_q;

    // R2
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && level_q != '0) |=> (level_q == $past(level_q) - 1'b1));

    // R2
    drain_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && level_q == '0) |=> (level_q == '0));

    // R3
    engage_level_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_q) |-> (level_q >= CAP_V));

    // R5
    release_level_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(thr_q) |-> (level_q < HALF_V));

endmodule

// File: rtl/wdg_gap_timer.sv
module wdg_gap_timer #(
    parameter int unsigned GAP_W   = 12,
    parameter int unsigned GAP_MAX = 2404
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [GAP_W-1:0] period,
    output logic             gap_ok
);
    localparam logic [GAP_W-1:0] SAT_V = GAP_W'(GAP_MAX);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= SAT_V;
        else if (take)
            cnt_q <= GAP_W'(1);
        else if (cnt_q < SAT_V)
            cnt_q <= cnt_q + 1'b1;
    end

    assign gap_ok = (cnt_q >= period);

    // R4
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= SAT_V) && (cnt_q != '0));

    // R4
    gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (cnt_q == GAP_W'(1)));

endmodule

// File: rtl/wdg_err_flag.sv
module wdg_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    // R7
    err_trip_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q);

endmodule

// File: rtl/burst_rate_wdg.sv
module burst_rate_wdg
    import burst_wdg_pkg::*;
#(
    parameter int unsigned INC_SHORT = DEF_INC_SHORT,
    parameter int unsigned INC_LONG  = DEF_INC_LONG,
    parameter int unsigned CAPACITY  = DEF_CAPACITY
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_req,
    input  logic width_long,
    input  logic err_clr,
    output logic pulse_grant,
    output logic wdg_err
);
    localparam int unsigned INC_MAX = max2(INC_SHORT, INC_LONG);
    localparam int unsigned LVL_W   = $clog2(CAPACITY + 2 * INC_MAX + 1);
    localparam int unsigned GAP_W   = $clog2(INC_MAX + 1);

    pw_sel_e          mode;
    logic [LVL_W-1:0] charge;
    logic [GAP_W-1:0] period;
    logic             throttle, trip, gap_ok, take, grant_q;

    assign mode   = pw_sel_e'(width_long);
    assign charge = (mode == PW_LONG) ? LVL_W'(INC_LONG) : LVL_W'(INC_SHORT);
    assign period = (mode == PW_LONG) ? GAP_W'(INC_LONG) : GAP_W'(INC_SHORT);
    assign take   = pulse_req && (!throttle || gap_ok);

    wdg_bucket #(.LVL_W(LVL_W), .CAPACITY(CAPACITY)) u_bucket (
        .clk(clk), .rst(rst), .take(take), .charge(charge),
        .throttle(throttle), .trip(trip)
    );

    wdg_gap_timer #(.GAP_W(GAP_W), .GAP_MAX(INC_MAX)) u_gap (
        .clk(clk), .rst(rst), .take(take), .period(period), .gap_ok(gap_ok)
    );

    wdg_err_flag u_err (
        .clk(clk), .rst(rst), .set(trip), .clr(err_clr), .flag(wdg_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= 1'b0;
        else
            grant_q <= take;
    end

    assign pulse_grant = grant_q;

    // R1
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_grant |-> $past(pulse_req));

    // R1
    free_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_req && !throttle) |=> pulse_grant);

    // R6
    err_with_throttle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(throttle) |-> $rose(wdg_err) || $past(wdg_err));

endmodule

// File: tb/burst_rate_wdg_test.sv
module burst_rate_wdg_test;

    localparam int INC_S = 219;
    localparam int INC_L = 2404;
    localparam int CAP   = 4096;
    localparam int GMAX  = 2404;
    localparam int LIMIT = 190000;

    typedef struct packed {
        bit w;
        int gap;
        int n;
        int exp_g;
        bit exp_e;
    } row_t;

    // width, spacing, pulses, expected grants, expected flag
    localparam row_t ROWS [5] = '{
        '{1'b0, 219,  40, 40, 1'b0},   // R8 short at continuous rate
        '{1'b1, 2404,  8,  8, 1'b0},   // R8 long at continuous rate
        '{1'b0, 100,  20, 20, 1'b0},   // R2 moderate short burst
        '{1'b1, 1202,  2,  2, 1'b0},   // R2 short long-pulse burst
        '{1'b0, 62,   20, 20, 1'b0}    // R2 short 2 MHz burst
    };

    logic clk = 1'b0, rst = 1'b1, req = 1'b0, wl = 1'b0, clr = 1'b0;
    logic grant, err;

    always #4 clk = ~clk;

    burst_rate_wdg uut (
        .clk(clk), .rst(rst), .pulse_req(req), .width_long(wl),
        .err_clr(clr), .pulse_grant(grant), .wdg_err(err)
    );

    int checks = 0, fails = 0, mism = 0, cyc = 0;

    // Reference model built from the requirements
    int m_lvl = 0, m_gap = GMAX;
    bit m_thr = 0, m_err = 0, m_grant = 0;

    always @(posedge clk) begin : ref_model
        int inc_v, nl;
        bit g;
        inc_v = wl ? INC_L : INC_S;
        if (rst) begin
            m_lvl = 0; m_gap = GMAX; m_thr = 0; m_err = 0; m_grant = 0;
        end else begin
            g  = req && (!m_thr || m_gap >= inc_v);
            nl = (m_lvl > 0 ? m_lvl - 1 : 0) + (g ? inc_v : 0);
            if (nl >= CAP) m_thr = 1; else if (nl < CAP / 2) m_thr = 0;
            if (nl >= CAP) m_err = 1; else if (clr) m_err = 0;
            m_gap   = g ? 1 : (m_gap < GMAX ? m_gap + 1 : GMAX);
            m_lvl   = nl;
            m_grant = g;
        end
    end

    always @(negedge clk) begin
        if (!rst && (grant !== m_grant || err !== m_err)) mism++;
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit w, output bit got);
        req = 1'b1; wl = w;
        @(negedge clk);
        req = 1'b0;
        got = grant;
    endtask

    task automatic clear_flag();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Pulses until the first drop; returns how many were granted before it
    task automatic burst_to_drop(input bit w, input int gap, input int maxn, output int ngr);
        bit got;
        ngr = -1;
        for (int i = 0; i < maxn; i++) begin
            pulse(w, got);
            if (!got) begin
                ngr = i;
                break;
            end
            idle(gap - 1);
        end
    endtask

    function automatic int trip_count(input int inc, input int gap);
        for (int n = 1; n < 1000; n++)
            if (inc + (inc - gap) * (n - 1) >= CAP) return n;
        return -1;
    endfunction

    initial begin
        bit g1, g2;
        int ngr, exp_n, cnt;

        // R9 reset state
        idle(3);
        check(grant == 1'b0 && err == 1'b0, "R9 reset outputs", {grant, err}, 0);
        rst = 1'b0;
        idle(5);

        // R3 short 2 MHz burst trips after computed count
        exp_n = trip_count(INC_S, 62);
        burst_to_drop(1'b0, 62, 60, ngr);
        check(ngr == exp_n, "R3 short burst grants before drop", ngr, exp_n);
        check(err == 1'b1, "R6 flag set at trip", err, 1);

        // R4 throttled: gap of 263 cycles since last grant passes
        idle(200);
        pulse(1'b0, g1);
        check(g1 == 1'b1, "R4 throttled pulse after full period", g1, 1);
        // R5 still above half capacity: 62-cycle follow-up dropped
        idle(61);
        pulse(1'b0, g2);
        check(g2 == 1'b0, "R5 still throttled above half", g2, 0);

        // R5 drained below half: burst passes again
        idle(6000);
        pulse(1'b0, g1);
        idle(61);
        pulse(1'b0, g2);
        check(g1 == 1'b1 && g2 == 1'b1, "R5 released after drain", {g1, g2}, 3);
        check(err == 1'b1, "R6 flag sticky after release", err, 1);

        // R7 explicit clear
        clear_flag();
        check(err == 1'b0, "R7 flag cleared", err, 0);

        // R3 long 104 kHz burst
        idle(6000);
        exp_n = trip_count(INC_L, 1202);
        burst_to_drop(1'b1, 1202, 20, ngr);
        check(ngr == exp_n, "R3 long burst grants before drop", ngr, exp_n);
        check(err == 1'b1, "R6 flag set by long burst", err, 1);

        // R9 reset while throttled
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check(err == 1'b0, "R9 flag low after reset", err, 0);
        pulse(1'b0, g1);
        idle(61);
        pulse(1'b0, g2);
        check(g1 == 1'b1 && g2 == 1'b1, "R9 grants after reset", {g1, g2}, 3);

        // Table of patterns (R1 R2 R8)
        for (int r = 0; r < 5; r++) begin
            idle(6000);
            clear_flag();
            cnt = 0;
            for (int i = 0; i < ROWS[r].n; i++) begin
                pulse(ROWS[r].w, g1);
                cnt += int'(g1);
                if (i < ROWS[r].n - 1) idle(ROWS[r].gap - 1);
            end
            check(cnt == ROWS[r].exp_g, "R1 row grant count", cnt, ROWS[r].exp_g);
            check(err == ROWS[r].exp_e, "R8 row flag", err, int'(ROWS[r].exp_e));
        end

        // R1 cycle agreement with reference model over the whole run
        check(mism == 0, "R1 cycle mismatches vs model", mism, 0);
        report();
    end

endmodule